// File: doc/BRIEF.md
# Half-Precision Running-Sum Accumulator with Deferred Normalization

This block adds a stream of 16-bit floating-point words into one running sum. The sum is held as a pair: an unsigned exponent and a wide two's-complement mantissa. Each accepted word is split into its fields. The hidden leading one is put back, and the significand is negated when the sign bit is set. The operand with the smaller exponent is then right-shifted to line up with the other, and the two are added as plain signed integers. The pair keeps the larger exponent.

The mantissa is never renormalized. It can grow past its original eleven bits or shrink toward zero without any change to the exponent. Leading-zero counting, rounding and repacking are left to whatever reads the pair later.

A consumer clears the sum with a one-cycle strobe and then presents one word per clock with a valid flag. There is no backpressure. The sum can be read at any time from the two output buses.

Top module: `dnorm_accum`

## Requirements
- R1: An input word carries the sign in bit 15, the biased exponent in bits 14:10 and the fraction in bits 9:0. Its significand is 1024 plus the fraction, negated in two's complement when bit 15 is 1. When the input reaches a cleared sum, the next cycle shows the word's exponent field on `acc_exp` and the signed significand, sign-extended to 24 bits, on `acc_man`.
- R2: When the incoming exponent is greater than the stored exponent, the stored mantissa is aligned right by the difference before the add, and `acc_exp` takes the incoming exponent.
- R3: When the incoming exponent is less than or equal to the stored exponent, the incoming significand is aligned right by the difference before the add, and `acc_exp` is unchanged.
- R4: After every accepted input, `acc_exp` equals the larger of its previous value and the input's exponent field.
- R5: Alignment shifts the magnitude and restores the sign afterwards, so discarded bits truncate toward zero with no rounding. A shift of 24 or more gives zero, which leaves the sum unchanged when the input is the smaller operand.
- R6: No renormalization takes place. The mantissa is the exact 24-bit two's-complement sum of the aligned operands and wraps modulo 2^24 when it overflows.
- R7: While `clr` is high, the next cycle shows 0 on both `acc_exp` and `acc_man`. `clr` takes priority over a simultaneous valid input, and that input is discarded.
- R8: A cycle with neither `clr` nor `in_valid` leaves both outputs unchanged.
- R9: While `rst_n` is low, both outputs are 0.
- R10: One input is accepted on every clock on which `in_valid` is high. Each input is reflected on the outputs in the next cycle, so back-to-back inputs all count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the running sum |
| in_valid | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | 16 | Half-precision input word |
| acc_exp | output | 5 | Stored biased exponent of the running sum |
| acc_man | output | 24 | Stored two's-complement mantissa of the running sum |

## Verification
The properties assume that `in_data` is a known value in every cycle where `in_valid` is high. They also assume that the stored mantissa never sits at the single value whose magnitude does not fit in 24 bits when an alignment shift is applied to it. The stimulus drives a defined word in every cycle, X never included. It reaches the overflow corner only in the long same-exponent run, where no shift is applied. The exponent-pair sweep covers every combination of stored and incoming exponent, including differences of 24 and above, so the swap and shift-out paths are both reached.

// File: rtl/dnorm_pkg.sv
package dnorm_pkg;

    // Which operand acts as the alignment reference.
    typedef enum logic {
        REF_STORED = 1'b0,
        REF_INPUT  = 1'b1
    } ref_sel_e;

endpackage

// File: rtl/dnorm_unpack.sv
module dnorm_unpack #(
    parameter int EXP_W  = 5,
    parameter int FRAC_W = 10,
    parameter int ACC_W  = 24,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int PAD_W  = ACC_W - FRAC_W - 1
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [EXP_W-1:0]  exp_o,
    output logic [ACC_W-1:0]  man_o
);

    logic              sign_w;
    logic [FRAC_W-1:0] frac_w;
    logic [ACC_W-1:0]  sig_ext;

    always_comb begin
        sign_w  = word_i[WORD_W-1];
        exp_o   = word_i[WORD_W-2:FRAC_W];
        frac_w  = word_i[FRAC_W-1:0];
        // hidden one restored, then zero-extended to the accumulator width
        sig_ext = {{PAD_W{1'b0}}, 1'b1, frac_w};
        man_o   = sign_w ? (~sig_ext + 1'b1) : sig_ext;
    end

endmodule

// File: rtl/dnorm_order.sv
module dnorm_order
    import dnorm_pkg::*;
#(
    parameter int EXP_W = 5,
    parameter int ACC_W = 24
) (
    input  logic [EXP_W-1:0] st_exp_i,
    input  logic [ACC_W-1:0] st_man_i,
    input  logic [EXP_W-1:0] in_exp_i,
    input  logic [ACC_W-1:0] in_man_i,
    output ref_sel_e         sel_o,
    output logic [EXP_W-1:0] res_exp_o,
    output logic [EXP_W-1:0] shift_o,
    output logic [ACC_W-1:0] ref_man_o,
    output logic [ACC_W-1:0] sml_man_o
);

    always_comb begin
        if (in_exp_i > st_exp_i) begin
            sel_o     = REF_INPUT;
            res_exp_o = in_exp_i;
            shift_o   = in_exp_i - st_exp_i;
            ref_man_o = in_man_i;
            sml_man_o = st_man_i;
        end else begin
            sel_o     = REF_STORED;
            res_exp_o = st_exp_i;
            shift_o   = st_exp_i - in_exp_i;
            ref_man_o = st_man_i;
            sml_man_o = in_man_i;
        end
    end

endmodule

// File: rtl/dnorm_align.sv
module dnorm_align #(
    parameter int ACC_W = 24,
    parameter int SH_W  = 5
) (
    input  logic [ACC_W-1:0] man_i,
    input  logic [SH_W-1:0]  shift_i,
    output logic [ACC_W-1:0] man_o
);

    logic             neg_w;
    logic [ACC_W-1:0] mag_w;
    logic [ACC_W-1:0] stage [0:SH_W];

    always_comb begin
        neg_w    = man_i[ACC_W-1];
        mag_w    = neg_w ? (~man_i + 1'b1) : man_i;
        stage[0] = mag_w;
    end

    // logarithmic shifter on the magnitude; shifting past the width yields zero
    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        always_comb begin
            stage[i+1] = shift_i[i] ? (stage[i] >> (1 << i)) : stage[i];
        end
    end

    always_comb begin
        man_o = neg_w ? (~stage[SH_W] + 1'b1) : stage[SH_W];
    end

endmodule

// File: rtl/dnorm_accum.sv
module dnorm_accum
    import dnorm_pkg::*;
#(
    parameter int EXP_W  = 5,
    parameter int FRAC_W = 10,
    parameter int ACC_W  = 24,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic [EXP_W-1:0]  acc_exp,
    output logic [ACC_W-1:0]  acc_man
);

    typedef struct packed {
        logic [EXP_W-1:0] exp;
        logic [ACC_W-1:0] man;
    } acc_t;

    acc_t acc_d, acc_q;

    logic [EXP_W-1:0] in_exp_w;
    logic [ACC_W-1:0] in_man_w;
    ref_sel_e         sel_w;
    logic [EXP_W-1:0] res_exp_w;
    logic [EXP_W-1:0] shift_w;
    logic [ACC_W-1:0] ref_man_w;
    logic [ACC_W-1:0] sml_man_w;
    logic [ACC_W-1:0] aligned_w;

    dnorm_unpack #(
        .EXP_W (EXP_W),
        .FRAC_W(FRAC_W),
        .ACC_W (ACC_W)
    ) u_unpack (
        .word_i(in_data),
        .exp_o (in_exp_w),
        .man_o (in_man_w)
    );

    dnorm_order #(
        .EXP_W(EXP_W),
        .ACC_W(ACC_W)
    ) u_order (
        .st_exp_i (acc_q.exp),
        .st_man_i (acc_q.man),
        .in_exp_i (in_exp_w),
        .in_man_i (in_man_w),
        .sel_o    (sel_w),
        .res_exp_o(res_exp_w),
        .shift_o  (shift_w),
        .ref_man_o(ref_man_w),
        .sml_man_o(sml_man_w)
    );

    dnorm_align #(
        .ACC_W(ACC_W),
        .SH_W (EXP_W)
    ) u_align (
        .man_i  (sml_man_w),
        .shift_i(shift_w),
        .man_o  (aligned_w)
    );

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d.exp = '0;
            acc_d.man = '0;
        end else if (in_valid) begin
            acc_d.exp = res_exp_w;
            // plain signed add, no renormalization; wraps at the width
            acc_d.man = (sel_w == REF_INPUT) ? (ref_man_w + aligned_w)
                                             : (acc_q.man + aligned_w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc_exp = acc_q.exp;
    assign acc_man = acc_q.man;

endmodule

// File: rtl/dnorm_accum_chk.sv
module dnorm_accum_chk #(
    parameter int EXP_W  = 5,
    parameter int FRAC_W = 10,
    parameter int ACC_W  = 24,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_data,
    input logic [EXP_W-1:0]  acc_exp,
    input logic [ACC_W-1:0]  acc_man
);

    logic [EXP_W-1:0] c_in_exp;
    logic [ACC_W-1:0] c_sig;
    logic [ACC_W-1:0] c_signed;
    logic             c_take;
    logic             c_empty;
    logic             c_far;

    always_comb begin
        c_in_exp = in_data[WORD_W-2:FRAC_W];
        c_sig    = ACC_W'(in_data[FRAC_W-1:0]) + (ACC_W'(1) << FRAC_W);
        c_signed = in_data[WORD_W-1] ? (ACC_W'(0) - c_sig) : c_sig;
        c_take   = in_valid && !clr;
        c_empty  = (acc_exp == '0) && (acc_man == '0);
        c_far    = (acc_exp >= c_in_exp) && ((32'(acc_exp) - 32'(c_in_exp)) >= ACC_W);
    end

    // R7: clear empties the pair on the next cycle
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_exp == '0) && (acc_man == '0));

    // R8: idle cycles hold the pair
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !in_valid) |=> ($stable(acc_exp) && $stable(acc_man)));

    // R4: exponent becomes the larger of the two
    p_exp_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        c_take |=> acc_exp == (($past(c_in_exp) > $past(acc_exp)) ? $past(c_in_exp)
                                                                   : $past(acc_exp)));

    // R1: an input into an empty sum appears as its own signed significand
    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (c_take && c_empty) |=> (acc_man == $past(c_signed)) && (acc_exp == $past(c_in_exp)));

    // R5: a smaller operand shifted out entirely leaves the sum alone
    p_shift_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_take && c_far) |=> ($stable(acc_man) && $stable(acc_exp)));

    // R9: reset state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_reset_r9: assert (acc_exp == '0 && acc_man == '0);
        end
    end

endmodule

bind dnorm_accum dnorm_accum_chk #(
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W),
    .ACC_W (ACC_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .in_valid(in_valid),
    .in_data (in_data),
    .acc_exp (acc_exp),
    .acc_man (acc_man)
);

// File: tb/dnorm_accum_tb.sv
module dnorm_accum_tb;

    localparam int CLK_HALF = 2;
    localparam int WD_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = 16'h0000;
    logic [4:0]  acc_exp;
    logic [23:0] acc_man;

    int n_checks = 0;
    int n_errors = 0;
    int m_exp = 0;
    int m_man = 0;
    bit finished = 1'b0;

    dnorm_accum u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .in_valid(in_valid),
        .in_data (in_data),
        .acc_exp (acc_exp),
        .acc_man (acc_man)
    );

    always #(CLK_HALF) clk = ~clk;

    function automatic int wrap24(int v);
        return (v <<< 8) >>> 8;
    endfunction

    // R5: magnitude shift, truncation toward zero, wide shifts give zero
    function automatic int align(int v, int sh);
        if (sh >= 24) return 0;
        if (v < 0) return wrap24(-((-v) >> sh));
        return v >> sh;
    endfunction

    function automatic void model(bit v, bit c, logic [15:0] d);
        int e;
        int s;
        if (c) begin
            m_exp = 0;
            m_man = 0;
        end else if (v) begin
            e = int'(d[14:10]);
            s = 1024 + int'(d[9:0]);
            if (d[15]) s = -s;
            if (e > m_exp) begin
                m_man = wrap24(align(m_man, e - m_exp) + s);
                m_exp = e;
            end else begin
                m_man = wrap24(m_man + align(s, m_exp - e));
            end
        end
    endfunction

    task automatic check(string req);
        int got_man;
        got_man = int'($signed(acc_man));
        n_checks++;
        if (int'(acc_exp) != m_exp || got_man != m_man) begin
            n_errors++;
            $display("FAIL %s: exp actual=%0d expected=%0d man actual=%0d expected=%0d",
                     req, acc_exp, m_exp, got_man, m_man);
        end
    endtask

    // called at a falling edge; result sampled at the next falling edge
    task automatic cycle(bit v, bit c, logic [15:0] d, string req);
        in_valid = v;
        clr      = c;
        in_data  = d;
        @(negedge clk);
        model(v, c, d);
        check(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after release");

        // exponent-pair sweep: every stored/incoming exponent combination
        for (int e1 = 0; e1 < 32; e1++) begin
            for (int e2 = 0; e2 < 32; e2++) begin
                logic [15:0] d1;
                logic [15:0] d2;
                d1 = {1'(e1 ^ (e2 >> 1)), 5'(e1), 10'((e1 * 37 + e2 * 11) % 1024)};
                d2 = {1'(e2), 5'(e2), 10'((e1 * 5 + e2 * 101 + 3) % 1024)};
                cycle(1'b0, 1'b1, 16'h0000, "R7 clear");
                cycle(1'b1, 1'b0, d1, "R1 load");
                if (e2 > e1)
                    cycle(1'b1, 1'b0, d2, "R2 input larger");
                else if (e1 - e2 >= 24)
                    cycle(1'b1, 1'b0, d2, "R5 shifted out");
                else
                    cycle(1'b1, 1'b0, d2, "R3 stored larger R4");
            end
        end

        // idle hold and clear priority
        cycle(1'b0, 1'b1, 16'h0000, "R7 clear");
        cycle(1'b1, 1'b0, 16'hC9A5, "R1 load negative");
        for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, 16'h7FFF, "R8 idle hold");
        cycle(1'b1, 1'b1, 16'h3C00, "R7 clear beats valid");

        // truncation toward zero for a negative aligned operand
        cycle(1'b1, 1'b0, 16'h4C00, "R1 load");
        cycle(1'b1, 1'b0, 16'hBC01, "R5 truncate toward zero");

        // long same-exponent run: mantissa grows without renormalization and wraps
        cycle(1'b0, 1'b1, 16'h0000, "R7 clear");
        for (int k = 0; k < 4200; k++) cycle(1'b1, 1'b0, 16'h7BFF, "R6 growth and wrap");

        // back-to-back mixed stream from a 16-bit LFSR
        begin
            logic [15:0] lf;
            lf = 16'hACE1;
            cycle(1'b0, 1'b1, 16'h0000, "R7 clear");
            for (int k = 0; k < 3000; k++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                cycle(lf[3] | lf[7], 1'b0, lf, "R10 back-to-back stream");
            end
        end

        in_valid = 1'b0;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule